// File: doc/BRIEF.md
# Console Clock Command Responder

This block answers real-time-clock commands from a console serial peripheral bus once the serial frames have been turned into bytes. Each command arrives as a 10-byte receive buffer: byte 0 carries the command code, byte 1 the block number, and the remaining bytes carry data. One cycle after the command is accepted, the block presents a 12-byte transmit buffer holding the answer.

The responder keeps a 7-byte time image, two write-protect bits and a running flag. Block 0 holds the control state: the stop bit and the write-protect bits. Block 2 holds the calendar time. A write to the time block does not change the time image directly. It loads a new-time buffer and raises a pending flag for a downstream clock-sync engine. That engine takes the new time with a one-cycle accept pulse and returns the live time through its own update strobe, and that update is what drives the stored image.

Top module: `rtc_cmd_responder`

## Requirements
- R1: After a synchronous active-low reset, the outputs are as follows: `resp_valid` is 0, `tx_buf` is all zero, `running` is 1, `wp_bits` is 0 and `new_time_pending` is 0.
- R2: A command with code 0x07 (read) or 0x08 (write) in receive byte 0 gives `resp_valid` high in the following cycle. Any other command code gives no response and changes no state.
- R3: A read of block 0 puts the control byte at transmit index 1. That byte is 0x04 (the stop mask) when `running` is 0, and 0x00 when `running` is 1.
- R4: A read of block 2 returns the time image byte i at transmit index i, for i from 0 to 6, and the century code 0x01 (meaning 20xx) at index 7.
- R5: Every response, whether to a read or a write, carries a status byte at transmit index 8. It is 0x80 if `running` was 0 when the command arrived, and 0x00 otherwise.
- R6: A write to block 0 sets `wp_bits` to receive byte 2 AND 0x03. It sets `running` to the inverse of bit 2 of receive byte 3. Both changes are visible the cycle after the command.
- R7: A write to block 2 sets `new_time` byte i to receive byte i+2, for i from 0 to 6, and raises `new_time_pending`. It leaves the time image unchanged.
- R8: A pulse on `new_time_accept` clears `new_time_pending` in the next cycle. A block-2 write in the same cycle wins, and the flag stays set.
- R9: Writes to any block other than 0 and 2 are answered and have no effect on any state. Reads of any other block return zero in indices 0 to 7.
- R10: A pulse on `time_upd_valid` loads `time_upd` into the time image, and the next block-2 read returns it.
- R11: Every transmit byte that the addressed command does not define is zero. This covers indices 9 to 11 always, and indices 0 to 7 of every write response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe: rx_buf holds a command |
| rx_buf | input | 80 | Receive bytes; byte i at bits 8i+7:8i |
| resp_valid | output | 1 | Response in tx_buf is valid this cycle |
| tx_buf | output | 96 | Transmit bytes; byte i at bits 8i+7:8i |
| time_upd_valid | input | 1 | Strobe from the sync engine: load the time image |
| time_upd | input | 56 | Current time from the sync engine, byte i at 8i |
| new_time | output | 56 | Time written by the host, for the sync engine |
| new_time_pending | output | 1 | new_time holds data the engine has not yet taken |
| new_time_accept | input | 1 | One-cycle pulse: the engine has taken new_time |
| wp_bits | output | 8 | Latched write-protect bits |
| running | output | 1 | Clock running flag (inverse of the stop bit) |

## Verification
The control block is read in both running states, so the stop mask and the status byte are each seen at both values. The control block is also written once with the stop bit set and once with it clear, with high-order noise in the write-protect byte, which separates correct masking from a plain copy. The time block is tested with distinct byte values, so a swapped or shifted byte would show. Two further patterns check the pending flag: a write alone and a write coinciding with an accept, which together expose a wrong priority. Commands to unused blocks, an unknown command code and back-to-back commands confirm that nothing outside the two blocks leaks into state or into the response.

// File: rtl/rtc_resp_pkg.sv
// Shared constants for the clock command responder.
// Assumes byte-wide fields; codes are fixed by the bus protocol.
package rtc_resp_pkg;
    localparam int          BYTE_W         = 8;
    localparam logic [7:0]  CMD_READ       = 8'h07;
    localparam logic [7:0]  CMD_WRITE      = 8'h08;
    localparam logic [7:0]  BLK_CTRL       = 8'h00;
    localparam logic [7:0]  BLK_TIME       = 8'h02;
    localparam logic [7:0]  STOP_MASK      = 8'h04;
    localparam logic [7:0]  WP_MASK        = 8'h03;
    localparam logic [7:0]  CENTURY_CODE   = 8'h01;
    localparam logic [7:0]  STATUS_STOPPED = 8'h80;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;
endpackage

// File: rtl/rtc_ctrl_regs.sv
// Control block state: write-protect bits and running flag.
// Assumes we is a one-cycle strobe from the command decoder.
module rtc_ctrl_regs
    import rtc_resp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [BYTE_W-1:0] wp_in,
    input  logic [BYTE_W-1:0] stop_in,
    output logic [BYTE_W-1:0] wp_bits,
    output logic              running
);
    // Latch control fields on a block-0 write; clock runs out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_bits <= '0;
            running <= 1'b1;
        end else if (we) begin
            wp_bits <= wp_in & WP_MASK;
            running <= ((stop_in & STOP_MASK) == '0);
        end
    end
endmodule

// File: rtl/rtc_time_store.sv
// Time image, host new-time buffer and pending handshake.
// Assumes the sync engine pulses accept once per taken value;
// a host write in the same cycle as accept keeps the flag set.
module rtc_time_store
    import rtc_resp_pkg::*;
#(
    parameter int TIME_LEN = 7,
    localparam int TIME_W  = TIME_LEN * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_valid,
    input  logic [TIME_W-1:0] upd_data,
    input  logic              we,
    input  logic [TIME_W-1:0] wr_data,
    input  logic              accept,
    output logic [TIME_W-1:0] time_img,
    output logic [TIME_W-1:0] new_time,
    output logic              pending
);
    // Time image follows the sync engine's updates only.
    always_ff @(posedge clk) begin
        if (!rst_n)         time_img <= '0;
        else if (upd_valid) time_img <= upd_data;
    end

    // Host writes load the buffer; write beats accept on the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            new_time <= '0;
            pending  <= 1'b0;
        end else if (we) begin
            new_time <= wr_data;
            pending  <= 1'b1;
        end else if (accept) begin
            pending  <= 1'b0;
        end
    end
endmodule

// File: rtl/rtc_resp_build.sv
// Builds and registers the transmit buffer for one command.
// Assumes op is OP_NONE except in a command cycle; unused bytes are zero.
module rtc_resp_build
    import rtc_resp_pkg::*;
#(
    parameter int TX_LEN   = 12,
    parameter int TIME_LEN = 7,
    localparam int TX_W    = TX_LEN * BYTE_W,
    localparam int TIME_W  = TIME_LEN * BYTE_W,
    localparam int CENT_IDX = TIME_LEN,
    localparam int STAT_IDX = TIME_LEN + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_e               op,
    input  logic [BYTE_W-1:0] blk,
    input  logic [TIME_W-1:0] time_img,
    input  logic              running,
    output logic              resp_valid,
    output logic [TX_W-1:0]   tx_buf
);
    logic [TX_W-1:0] tx_next;

    // Assemble the response from current state before any update.
    always_comb begin
        tx_next = '0;
        if (op != OP_NONE)
            tx_next[STAT_IDX*BYTE_W +: BYTE_W] = running ? '0 : STATUS_STOPPED;
        if (op == OP_READ) begin
            if (blk == BLK_CTRL) begin
                tx_next[1*BYTE_W +: BYTE_W] = running ? '0 : STOP_MASK;
            end else if (blk == BLK_TIME) begin
                tx_next[0 +: TIME_W]               = time_img;
                tx_next[CENT_IDX*BYTE_W +: BYTE_W] = CENTURY_CODE;
            end
        end
    end

    // Register the response one cycle after the command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            tx_buf     <= '0;
        end else begin
            resp_valid <= (op != OP_NONE);
            if (op != OP_NONE) tx_buf <= tx_next;
        end
    end
endmodule

// File: rtl/rtc_cmd_responder.sv
// Top: decodes the command buffer and steers it to the control
// registers, the time store and the response builder.
// Assumes cmd_valid is a one-cycle strobe with rx_buf stable alongside it.
module rtc_cmd_responder
    import rtc_resp_pkg::*;
#(
    parameter int RX_LEN   = 10,
    parameter int TX_LEN   = 12,
    parameter int TIME_LEN = 7,
    localparam int RX_W    = RX_LEN * BYTE_W,
    localparam int TX_W    = TX_LEN * BYTE_W,
    localparam int TIME_W  = TIME_LEN * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [RX_W-1:0]   rx_buf,
    output logic              resp_valid,
    output logic [TX_W-1:0]   tx_buf,
    input  logic              time_upd_valid,
    input  logic [TIME_W-1:0] time_upd,
    output logic [TIME_W-1:0] new_time,
    output logic              new_time_pending,
    input  logic              new_time_accept,
    output logic [BYTE_W-1:0] wp_bits,
    output logic              running
);
    logic [BYTE_W-1:0] rx_b [RX_LEN];
    logic [TIME_W-1:0] time_img;
    op_e               op;
    logic              ctrl_we;
    logic              time_we;

    // Split the flat receive buffer into bytes.
    for (genvar i = 0; i < RX_LEN; i++) begin : g_rx
        assign rx_b[i] = rx_buf[i*BYTE_W +: BYTE_W];
    end

    // Command decode: known codes only, qualified by the strobe.
    always_comb begin
        op = OP_NONE;
        if (cmd_valid && rx_b[0] == CMD_READ)  op = OP_READ;
        if (cmd_valid && rx_b[0] == CMD_WRITE) op = OP_WRITE;
        ctrl_we = (op == OP_WRITE) && (rx_b[1] == BLK_CTRL);
        time_we = (op == OP_WRITE) && (rx_b[1] == BLK_TIME);
    end

    rtc_ctrl_regs u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (ctrl_we),
        .wp_in   (rx_b[2]),
        .stop_in (rx_b[3]),
        .wp_bits (wp_bits),
        .running (running)
    );

    rtc_time_store #(.TIME_LEN(TIME_LEN)) u_time (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_valid (time_upd_valid),
        .upd_data  (time_upd),
        .we        (time_we),
        .wr_data   (rx_buf[2*BYTE_W +: TIME_W]),
        .accept    (new_time_accept),
        .time_img  (time_img),
        .new_time  (new_time),
        .pending   (new_time_pending)
    );

    rtc_resp_build #(.TX_LEN(TX_LEN), .TIME_LEN(TIME_LEN)) u_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (op),
        .blk        (rx_b[1]),
        .time_img   (time_img),
        .running    (running),
        .resp_valid (resp_valid),
        .tx_buf     (tx_buf)
    );
endmodule

// File: rtl/rtc_cmd_responder_chk.sv
// Port-level checker for the clock command responder, bound to the top.
module rtc_cmd_responder_chk
    import rtc_resp_pkg::*;
#(
    parameter int RX_LEN   = 10,
    parameter int TX_LEN   = 12,
    parameter int TIME_LEN = 7,
    localparam int RX_W    = RX_LEN * BYTE_W,
    localparam int TX_W    = TX_LEN * BYTE_W,
    localparam int TIME_W  = TIME_LEN * BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [RX_W-1:0]   rx_buf,
    input logic              resp_valid,
    input logic [TX_W-1:0]   tx_buf,
    input logic [TIME_W-1:0] new_time,
    input logic              new_time_pending,
    input logic              new_time_accept,
    input logic [BYTE_W-1:0] wp_bits,
    input logic              running
);
    logic is_wr, is_rd, known_blk;
    assign is_rd     = cmd_valid && rx_buf[7:0] == CMD_READ;
    assign is_wr     = cmd_valid && rx_buf[7:0] == CMD_WRITE;
    assign known_blk = rx_buf[15:8] == BLK_CTRL || rx_buf[15:8] == BLK_TIME;

    assert_resp_needs_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_rd || is_wr) |=> !resp_valid);

    assert_resp_follows_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd || is_wr) |=> resp_valid);

    assert_status_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd || is_wr) |=> tx_buf[(TIME_LEN+1)*BYTE_W +: BYTE_W] ==
            ($past(running) ? 8'h00 : STATUS_STOPPED));

    assert_ctrl_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_wr && rx_buf[15:8] == BLK_CTRL) |=>
            running == ($past(rx_buf[26]) == 1'b0) && wp_bits == ($past(rx_buf[23:16]) & WP_MASK));

    assert_time_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_wr && rx_buf[15:8] == BLK_TIME) |=>
            new_time_pending && new_time == $past(rx_buf[2*BYTE_W +: TIME_W]));

    assert_accept_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (new_time_accept && !(is_wr && rx_buf[15:8] == BLK_TIME)) |=> !new_time_pending);

    assert_other_write_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_wr && !known_blk) |=>
            $stable(running) && $stable(wp_bits) && $stable(new_time));

    assert_high_bytes_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> tx_buf[TX_W-1 : (TIME_LEN+2)*BYTE_W] == '0);
endmodule

bind rtc_cmd_responder rtc_cmd_responder_chk #(
    .RX_LEN(RX_LEN), .TX_LEN(TX_LEN), .TIME_LEN(TIME_LEN)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .cmd_valid        (cmd_valid),
    .rx_buf           (rx_buf),
    .resp_valid       (resp_valid),
    .tx_buf           (tx_buf),
    .new_time         (new_time),
    .new_time_pending (new_time_pending),
    .new_time_accept  (new_time_accept),
    .wp_bits          (wp_bits),
    .running          (running)
);

// File: tb/rtc_cmd_responder_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver predicts each response and queues it;
// the monitor pops and compares whenever resp_valid is seen.
module rtc_cmd_responder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [79:0] rx_buf = '0;
    logic        resp_valid;
    logic [95:0] tx_buf;
    logic        time_upd_valid = 1'b0;
    logic [55:0] time_upd = '0;
    logic [55:0] new_time;
    logic        new_time_pending;
    logic        new_time_accept = 1'b0;
    logic [7:0]  wp_bits;
    logic        running;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // model state
    bit          m_run = 1'b1;
    logic [7:0]  m_wp = '0;
    logic [55:0] m_img = '0;
    logic [55:0] m_new = '0;
    bit          m_pend = 1'b0;

    logic [95:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    rtc_cmd_responder uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .rx_buf(rx_buf),
        .resp_valid(resp_valid), .tx_buf(tx_buf),
        .time_upd_valid(time_upd_valid), .time_upd(time_upd),
        .new_time(new_time), .new_time_pending(new_time_pending),
        .new_time_accept(new_time_accept), .wp_bits(wp_bits), .running(running)
    );

    task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Send one command; predict the response and the state from the model.
    task automatic send(input logic [7:0] c, input logic [7:0] b, input logic [63:0] d,
                        input bit acc, input string tag);
        logic [95:0] e;
        e = '0;
        if (c == 8'h07 || c == 8'h08) begin
            e[71:64] = m_run ? 8'h00 : 8'h80;
            if (c == 8'h07 && b == 8'h00) e[15:8] = m_run ? 8'h00 : 8'h04;
            if (c == 8'h07 && b == 8'h02) begin
                e[55:0]  = m_img;
                e[63:56] = 8'h01;
            end
            exp_q.push_back(e);
            tag_q.push_back(tag);
        end
        if (c == 8'h08 && b == 8'h00) begin
            m_wp  = d[7:0] & 8'h03;
            m_run = (d[10] == 1'b0);
        end
        if (c == 8'h08 && b == 8'h02) begin
            m_new  = d[55:0];
            m_pend = 1'b1;
        end else if (acc) begin
            m_pend = 1'b0;
        end
        rx_buf = {d, b, c};
        cmd_valid = 1'b1;
        new_time_accept = acc;
        @(negedge clk);
        cmd_valid = 1'b0;
        new_time_accept = 1'b0;
    endtask

    task automatic check_state(input string req);
        chk(running == m_run, req, {95'd0, running}, {95'd0, m_run});
        chk(wp_bits == m_wp, req, {88'd0, wp_bits}, {88'd0, m_wp});
        chk(new_time_pending == m_pend, req, {95'd0, new_time_pending}, {95'd0, m_pend});
        chk(new_time == m_new, req, {40'd0, new_time}, {40'd0, m_new});
    endtask

    // Monitor: compare each response against the oldest prediction.
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected response", tx_buf, '0);
            end else begin
                logic [95:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(tx_buf === e, t, tx_buf, e);
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(resp_valid == 1'b0, "R1 resp_valid", {95'd0, resp_valid}, '0);
        chk(tx_buf == '0, "R1 tx_buf", tx_buf, '0);
        check_state("R1 state");

        // R3 R5 read control while running
        send(8'h07, 8'h00, '0, 1'b0, "R3 R5 read ctrl running");
        // R6 write control: stop bit set, noisy wp byte
        send(8'h08, 8'h00, 64'h0000_0000_0000_04FF, 1'b0, "R11 R5 write ctrl stop");
        @(negedge clk);
        check_state("R6 stop written");
        send(8'h07, 8'h00, '0, 1'b0, "R3 R5 read ctrl stopped");
        send(8'h08, 8'h00, 64'h0000_0000_0000_FB06, 1'b0, "R11 write ctrl run");
        @(negedge clk);
        check_state("R6 run written");

        // R10 time update then R4 read
        time_upd = 56'h21_09_01_06_90_30_10;
        time_upd_valid = 1'b1;
        m_img = time_upd;
        @(negedge clk);
        time_upd_valid = 1'b0;
        send(8'h07, 8'h02, '0, 1'b0, "R4 R10 read time");

        // R7 write time: buffer loaded, image untouched
        send(8'h08, 8'h02, 64'hEE_77_66_55_44_33_22_11, 1'b0, "R11 write time");
        @(negedge clk);
        check_state("R7 time written");
        send(8'h07, 8'h02, '0, 1'b0, "R7 image unchanged");

        // R8 accept clears, write beats accept
        new_time_accept = 1'b1;
        m_pend = 1'b0;
        @(negedge clk);
        new_time_accept = 1'b0;
        @(negedge clk);
        check_state("R8 accept clears");
        send(8'h08, 8'h02, 64'h00_17_16_15_14_13_12_A5, 1'b1, "R11 write with accept");
        @(negedge clk);
        check_state("R8 write wins");
        new_time_accept = 1'b1;
        m_pend = 1'b0;
        @(negedge clk);
        new_time_accept = 1'b0;
        @(negedge clk);
        check_state("R8 accept after");

        // R9 other blocks
        send(8'h08, 8'h05, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R9 write blk5 resp");
        @(negedge clk);
        check_state("R9 write blk5 inert");
        send(8'h07, 8'h01, '0, 1'b0, "R9 read blk1 zeros");
        send(8'h07, 8'h03, '0, 1'b0, "R9 read blk3 zeros");

        // R2 unknown command: no response, no state change
        send(8'h00, 8'h00, 64'h0000_0000_0000_04FF, 1'b0, "R2 bad cmd");
        @(negedge clk);
        @(negedge clk);
        check_state("R2 bad cmd inert");

        // back-to-back reads after stopping again
        send(8'h08, 8'h00, 64'h0000_0000_0000_0401, 1'b0, "R5 write ctrl stop2");
        send(8'h07, 8'h02, '0, 1'b0, "R4 R5 read time stopped");
        send(8'h07, 8'h00, '0, 1'b0, "R3 read ctrl b2b");
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all responses seen", exp_q.size(), 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule